// File: doc/BRIEF.md
# Rectangle Copy Engine with Overlap-Safe Scan Order

This block copies a rectangular region of 8-bit pixels from one place to another inside a single linear frame buffer. The host presents packed source corner, destination corner and size words together with a raster-operation word, a plane-mask word and a control-plane word, then pulses `start`. The engine walks the rectangle pixel by pixel through a byte-wide single-port synchronous RAM port. For each pixel it reads the source byte, reads the destination byte, and writes back the result of a masked raster operation.

The row and column scan directions are picked from where the destination sits relative to the source, so a copy whose source and destination overlap produces the same result as a copy through a separate scratch buffer. The requested size is clamped to the buffer dimensions. A pixel whose linear source or destination offset falls outside the buffer is skipped without a memory access and the scan goes on. `busy` stays high from the cycle after an accepted start until the cycle of the one-cycle `done` pulse.

Top module: `rect_copy_engine`

## Requirements
- R1: Every coordinate word carries X in bits 31:16 and Y in bits 15:0, and a pixel at (x, y) sits at linear offset y * BUF_W + x (BUF_W = 64, BUF_H = 32 by default).
- R2: When destination Y is greater than source Y the rows are visited from the last row of the rectangle back to the first; otherwise from the first row forward.
- R3: When destination X is greater than source X the pixels of a row are visited from the rightmost column to the leftmost; otherwise from leftmost to rightmost.
- R4: A requested width above BUF_W is treated as BUF_W and a requested height above BUF_H as BUF_H.
- R5: A pixel whose source or destination linear offset is at or above BUF_W * BUF_H is skipped in one cycle with no write, and the scan continues with the next pixel.
- R6: The raster-op code is rop_word[11:8]: 0 clears, 3 replaces with the source, 6 XORs the source in, 10 inverts the destination, 15 sets; any other code leaves the destination unchanged. Only bits selected by plane_word[7:0] change; the others keep their destination value.
- R7: If ctrl_plane is nonzero when start is accepted, no memory write occurs and done pulses in the cycle after the start.
- R8: busy is high from the cycle after an accepted start through the done cycle; a start pulse while busy is ignored, and done is a single-cycle pulse.
- R9: A copied pixel takes three cycles: source read, destination read, then a write to the address just read; a zero width or height finishes with done in the next cycle and no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only while idle |
| src_xy | input | 32 | Source corner, X in 31:16, Y in 15:0 |
| dst_xy | input | 32 | Destination corner, X in 31:16, Y in 15:0 |
| size_wh | input | 32 | Width in 31:16, height in 15:0 |
| rop_word | input | 32 | Raster-op code in bits 11:8 |
| plane_word | input | 32 | Plane mask in bits 7:0 |
| ctrl_plane | input | 32 | Nonzero suppresses the copy |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 11 | Frame buffer byte address |
| mem_we | output | 1 | Frame buffer write enable |
| mem_wdata | output | 8 | Frame buffer write data |
| mem_rdata | input | 8 | Frame buffer read data, one cycle after the address |

## Verification
The hardest situation to reach is an overlapping copy in which a wrong scan direction would read a pixel already overwritten by the same operation; the stimulus places source and destination a few pixels apart in both diagonal directions and along one axis only, and compares the whole buffer with a model that copies in the required order. Skipping is reached by a clamped oversize rectangle whose destination runs off the end of the buffer and by a source that starts near the last row, where the cycle count also shows one cycle per skipped pixel. A start pulse is driven in the middle of a running copy with parameters that would visibly damage the buffer if accepted.

// File: rtl/rce_pkg.sv
package rce_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSRC,
    ST_RDST,
    ST_WR,
    ST_DONE
  } rce_state_e;

  localparam logic [3:0] ROP_CLEAR  = 4'd0;
  localparam logic [3:0] ROP_COPY   = 4'd3;
  localparam logic [3:0] ROP_XOR    = 4'd6;
  localparam logic [3:0] ROP_INVERT = 4'd10;
  localparam logic [3:0] ROP_SET    = 4'd15;

  typedef struct packed {
    logic [15:0] x;
    logic [15:0] y;
  } coord_t;

endpackage

// File: rtl/rce_rop.sv
module rce_rop #(
  parameter int PIX_W = 8
) (
  input  logic [3:0]       op,
  input  logic [PIX_W-1:0] mask,
  input  logic [PIX_W-1:0] src,
  input  logic [PIX_W-1:0] dst,
  output logic [PIX_W-1:0] res
);
  import rce_pkg::*;

  always_comb begin
    unique case (op)
      ROP_CLEAR:  res = dst & ~mask;
      ROP_COPY:   res = (dst & ~mask) | (src & mask);
      ROP_XOR:    res = dst ^ (src & mask);
      ROP_INVERT: res = dst ^ mask;
      ROP_SET:    res = dst | mask;
      default:    res = dst;
    endcase
  end

endmodule

// File: rtl/rce_scan.sv
module rce_scan #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] w,
  input  logic [CNT_W-1:0] h,
  output logic [CNT_W-1:0] line_cnt,
  output logic [CNT_W-1:0] col_cnt,
  output logic             last
);
  logic [CNT_W-1:0] line_d, col_d;
  logic             row_end;
  logic             cnt_en;

  assign row_end = (col_cnt == w - CNT_W'(1));
  assign last    = row_end && (line_cnt == h - CNT_W'(1));
  assign cnt_en  = clr | step;

  always_comb begin
    line_d = line_cnt;
    col_d  = col_cnt;
    if (clr) begin
      line_d = '0;
      col_d  = '0;
    end else if (step) begin
      if (row_end) begin
        col_d  = '0;
        line_d = line_cnt + CNT_W'(1);
      end else begin
        col_d = col_cnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt <= '0;
      col_cnt  <= '0;
    end else if (cnt_en) begin
      line_cnt <= line_d;
      col_cnt  <= col_d;
    end
  end

  // R4: the column counter never leaves the clamped width while stepping
  a_r4_col_in_width: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (col_cnt < w));

  // R2: the row counter never leaves the clamped height while stepping
  a_r2_line_in_height: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (line_cnt < h));

endmodule

// File: rtl/rce_addr.sv
module rce_addr #(
  parameter int BUF_W   = 64,
  parameter int BUF_H   = 32,
  parameter int COORD_W = 16,
  parameter int CNT_W   = 7,
  parameter int ADDR_W  = 11
) (
  input  logic [COORD_W-1:0] sx,
  input  logic [COORD_W-1:0] sy,
  input  logic [COORD_W-1:0] dx,
  input  logic [COORD_W-1:0] dy,
  input  logic [CNT_W-1:0]   line_cnt,
  input  logic [CNT_W-1:0]   col_cnt,
  input  logic [CNT_W-1:0]   w,
  input  logic [CNT_W-1:0]   h,
  input  logic               row_rev,
  input  logic               col_rev,
  output logic [ADDR_W-1:0]  src_addr,
  output logic [ADDR_W-1:0]  dst_addr,
  output logic               skip
);
  localparam int DEPTH = BUF_W * BUF_H;
  localparam int OFF_W = COORD_W + CNT_W + $clog2(BUF_W) + 2;

  logic [CNT_W-1:0] line_e, col_e;
  logic [OFF_W-1:0] src_off, dst_off;

  always_comb begin
    line_e = row_rev ? (h - CNT_W'(1) - line_cnt) : line_cnt;
    col_e  = col_rev ? (w - CNT_W'(1) - col_cnt)  : col_cnt;
    src_off = (OFF_W'(sy) + OFF_W'(line_e)) * OFF_W'(BUF_W)
            + OFF_W'(sx) + OFF_W'(col_e);
    dst_off = (OFF_W'(dy) + OFF_W'(line_e)) * OFF_W'(BUF_W)
            + OFF_W'(dx) + OFF_W'(col_e);
    skip     = (src_off >= OFF_W'(DEPTH)) || (dst_off >= OFF_W'(DEPTH));
    src_addr = src_off[ADDR_W-1:0];
    dst_addr = dst_off[ADDR_W-1:0];
  end

endmodule

// File: rtl/rect_copy_engine.sv
module rect_copy_engine #(
  parameter int BUF_W   = 64,
  parameter int BUF_H   = 32,
  parameter int PIX_W   = 8,
  parameter int COORD_W = 16,
  parameter int ADDR_W  = $clog2(BUF_W * BUF_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       src_xy,
  input  logic [31:0]       dst_xy,
  input  logic [31:0]       size_wh,
  input  logic [31:0]       rop_word,
  input  logic [31:0]       plane_word,
  input  logic [31:0]       ctrl_plane,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [PIX_W-1:0]  mem_wdata,
  input  logic [PIX_W-1:0]  mem_rdata
);
  import rce_pkg::*;

  localparam int MAX_DIM = (BUF_W > BUF_H) ? BUF_W : BUF_H;
  localparam int CNT_W   = $clog2(MAX_DIM + 1);

  // reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_int_n <= rst_meta;
    end
  end

  coord_t src_c, dst_c, size_c;
  assign src_c  = coord_t'(src_xy);
  assign dst_c  = coord_t'(dst_xy);
  assign size_c = coord_t'(size_wh);

  // clamped size
  logic [CNT_W-1:0] w_clamp, h_clamp;
  always_comb begin
    w_clamp = (size_c.x > COORD_W'(BUF_W)) ? CNT_W'(BUF_W) : CNT_W'(size_c.x);
    h_clamp = (size_c.y > COORD_W'(BUF_H)) ? CNT_W'(BUF_H) : CNT_W'(size_c.y);
  end

  rce_state_e        state_q, state_d;
  logic [COORD_W-1:0] sx_q, sy_q, dx_q, dy_q;
  logic [CNT_W-1:0]  w_q, h_q;
  logic              row_rev_q, col_rev_q;
  logic [3:0]        op_q;
  logic [PIX_W-1:0]  mask_q, src_pix_q;

  logic start_acc, suppress;
  logic step, scan_last, skip;
  logic [CNT_W-1:0] line_cnt, col_cnt;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [PIX_W-1:0] rop_res;
  logic cap_src;

  assign start_acc = start && (state_q == ST_IDLE);
  assign suppress  = (ctrl_plane != 32'd0) || (w_clamp == '0) || (h_clamp == '0);
  assign cap_src   = (state_q == ST_RDST);

  rce_scan #(.CNT_W(CNT_W)) u_scan (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr      (start_acc),
    .step     (step),
    .w        (w_q),
    .h        (h_q),
    .line_cnt (line_cnt),
    .col_cnt  (col_cnt),
    .last     (scan_last)
  );

  rce_addr #(
    .BUF_W(BUF_W), .BUF_H(BUF_H), .COORD_W(COORD_W),
    .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_addr (
    .sx       (sx_q),
    .sy       (sy_q),
    .dx       (dx_q),
    .dy       (dy_q),
    .line_cnt (line_cnt),
    .col_cnt  (col_cnt),
    .w        (w_q),
    .h        (h_q),
    .row_rev  (row_rev_q),
    .col_rev  (col_rev_q),
    .src_addr (src_addr),
    .dst_addr (dst_addr),
    .skip     (skip)
  );

  rce_rop #(.PIX_W(PIX_W)) u_rop (
    .op   (op_q),
    .mask (mask_q),
    .src  (src_pix_q),
    .dst  (mem_rdata),
    .res  (rop_res)
  );

  // next state and memory port
  always_comb begin
    state_d   = state_q;
    step      = 1'b0;
    mem_addr  = '0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) state_d = suppress ? ST_DONE : ST_RSRC;
      end
      ST_RSRC: begin
        mem_addr = src_addr;
        if (skip) begin
          step    = 1'b1;
          state_d = scan_last ? ST_DONE : ST_RSRC;
        end else begin
          state_d = ST_RDST;
        end
      end
      ST_RDST: begin
        mem_addr = dst_addr;
        state_d  = ST_WR;
      end
      ST_WR: begin
        mem_addr  = dst_addr;
        mem_we    = 1'b1;
        mem_wdata = rop_res;
        step      = 1'b1;
        state_d   = scan_last ? ST_DONE : ST_RSRC;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  // operand capture on an accepted start
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sx_q      <= '0;
      sy_q      <= '0;
      dx_q      <= '0;
      dy_q      <= '0;
      w_q       <= '0;
      h_q       <= '0;
      row_rev_q <= 1'b0;
      col_rev_q <= 1'b0;
      op_q      <= '0;
      mask_q    <= '0;
    end else if (start_acc) begin
      sx_q      <= src_c.x;
      sy_q      <= src_c.y;
      dx_q      <= dst_c.x;
      dy_q      <= dst_c.y;
      w_q       <= w_clamp;
      h_q       <= h_clamp;
      row_rev_q <= dst_c.y > src_c.y;
      col_rev_q <= dst_c.x > src_c.x;
      op_q      <= rop_word[11:8];
      mask_q    <= plane_word[PIX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   src_pix_q <= '0;
    else if (cap_src) src_pix_q <= mem_rdata;
  end

  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_DONE);

  // R9: each write lands on the address read in the previous cycle
  a_r9_write_after_read: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_we |-> (mem_addr == $past(mem_addr) && !$past(mem_we)));

  // R6: bits outside the plane mask keep their destination value
  a_r6_mask_protect: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_we |-> (((mem_wdata ^ mem_rdata) & ~mask_q) == '0));

  // R7: suppressed copy completes in the next cycle
  a_r7_ctrl_plane_skip: assert property (@(posedge clk) disable iff (!rst_int_n)
    (start && !busy && ctrl_plane != 32'd0) |=> (done && !mem_we));

  // R8: done is a single pulse and ends the busy window
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> (!done && !busy));

  // R8: busy only rises after a start request
  a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(busy) |-> $past(start));

endmodule

// File: tb/rect_copy_engine_tb.sv
module rect_copy_engine_tb;
  localparam int BW = 64;
  localparam int BH = 32;
  localparam int DEPTH = BW * BH;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] src_xy = '0, dst_xy = '0, size_wh = '0;
  logic [31:0] rop_word = '0, plane_word = '0, ctrl_plane = '0;
  logic        busy, done, mem_we;
  logic [10:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  logic [7:0] mem [DEPTH];
  logic [7:0] ref_mem [DEPTH];

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  rect_copy_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_xy(src_xy), .dst_xy(dst_xy), .size_wh(size_wh),
    .rop_word(rop_word), .plane_word(plane_word), .ctrl_plane(ctrl_plane),
    .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rop(input int code, input logic [7:0] m,
                                     input logic [7:0] s, input logic [7:0] d);
    case (code)
      0:  return d & ~m;
      3:  return (d & ~m) | (s & m);
      6:  return d ^ (s & m);
      10: return d ^ m;
      15: return d | m;
      default: return d;
    endcase
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 8'((i * 37 + seed * 11 + (i >> 6) * 5) & 255);
      ref_mem[i] = mem[i];
    end
  endtask

  // model of the copy built from R1..R6
  task automatic model(input int sx, input int sy, input int dx, input int dy,
                       input int w, input int h, input int code, input int m);
    int ww, hh, ln, cl, so, doff;
    ww = (w > BW) ? BW : w;
    hh = (h > BH) ? BH : h;
    for (int li = 0; li < hh; li++) begin
      ln = (dy > sy) ? (hh - 1 - li) : li;
      for (int ci = 0; ci < ww; ci++) begin
        cl = (dx > sx) ? (ww - 1 - ci) : ci;
        so = (sy + ln) * BW + sx + cl;
        doff = (dy + ln) * BW + dx + cl;
        if (so < DEPTH && doff < DEPTH)
          ref_mem[doff] = rop(code, 8'(m), ref_mem[so], ref_mem[doff]);
      end
    end
  endtask

  function automatic int diff_count();
    int n = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] !== ref_mem[i]) n++;
    return n;
  endfunction

  task automatic launch(input int sx, input int sy, input int dx, input int dy,
                        input int w, input int h, input int code, input int m,
                        input int ctl);
    @(negedge clk);
    src_xy = {16'(sx), 16'(sy)};
    dst_xy = {16'(dx), 16'(dy)};
    size_wh = {16'(w), 16'(h)};
    rop_word = 32'(code) << 8 | 32'h2300_0000;
    plane_word = 32'(m) | 32'hff00;
    ctrl_plane = 32'(ctl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int ncyc, output int nwr);
    ncyc = 0;
    nwr = 0;
    for (int k = 0; k < 20000; k++) begin
      if (busy) ncyc++;
      if (mem_we) nwr++;
      if (done) break;
      @(negedge clk);
    end
  endtask

  task automatic run(input string req, input int sx, input int sy, input int dx,
                     input int dy, input int w, input int h, input int code,
                     input int m, output int ncyc);
    int nwr;
    launch(sx, sy, dx, dy, w, h, code, m, 0);
    model(sx, sy, dx, dy, w, h, code, m);
    wait_done(ncyc, nwr);
    @(negedge clk);
    check(req, diff_count(), 0);
  endtask

  task automatic t_reset();
    check("R8 reset busy", int'(busy), 0);
    check("R8 reset done", int'(done), 0);
    check("R9 reset we", int'(mem_we), 0);
  endtask

  task automatic t_plain();
    int n;
    fill(1);
    run("R1 plain copy", 3, 2, 40, 20, 4, 3, 3, 8'hff, n);
    check("R9 three cycles per pixel", n, 3 * 12 + 1);
  endtask

  task automatic t_overlap();
    int n;
    fill(2);
    run("R2 R3 overlap down-right", 2, 2, 5, 4, 8, 6, 3, 8'hff, n);
    fill(3);
    run("R2 R3 overlap up-left", 6, 7, 3, 4, 9, 7, 3, 8'hff, n);
    fill(4);
    run("R3 overlap right same row", 1, 10, 3, 10, 12, 2, 3, 8'hff, n);
    fill(5);
    run("R2 overlap down same column", 20, 3, 20, 5, 3, 10, 3, 8'hff, n);
  endtask

  task automatic t_rops();
    int n;
    fill(6);
    run("R6 xor masked", 0, 0, 30, 10, 5, 4, 6, 8'h3c, n);
    run("R6 clear masked", 10, 10, 40, 2, 6, 3, 0, 8'hf0, n);
    run("R6 set masked", 10, 10, 40, 25, 6, 3, 15, 8'h0f, n);
    run("R6 invert masked", 1, 1, 50, 12, 4, 4, 10, 8'haa, n);
    run("R6 copy masked", 5, 5, 33, 28, 7, 2, 3, 8'h81, n);
    run("R6 unsupported code unchanged", 0, 0, 20, 20, 5, 5, 5, 8'hff, n);
  endtask

  task automatic t_clamp_skip();
    int n;
    fill(7);
    run("R4 R5 clamp with dest overrun", 0, 0, 10, 5, 1000, 1000, 3, 8'hff, n);
    fill(8);
    run("R5 source past end", 0, 30, 8, 2, 4, 4, 3, 8'hff, n);
    check("R5 skipped pixel one cycle", n, 8 * 3 + 8 + 1);
  endtask

  task automatic t_ctrl_plane();
    int n, nwr;
    fill(9);
    launch(0, 0, 10, 10, 5, 5, 3, 8'hff, 32'h4);
    wait_done(n, nwr);
    check("R7 done next cycle", n, 1);
    check("R7 no writes", nwr, 0);
    @(negedge clk);
    check("R7 buffer untouched", diff_count(), 0);
  endtask

  task automatic t_zero_size();
    int n, nwr;
    fill(10);
    launch(0, 0, 10, 10, 0, 5, 3, 8'hff, 0);
    wait_done(n, nwr);
    check("R9 zero width done", n, 1);
    check("R9 zero width no write", nwr, 0);
  endtask

  task automatic t_busy_start();
    int ndone = 0;
    fill(11);
    launch(4, 4, 30, 15, 4, 4, 3, 8'hff, 0);
    model(4, 4, 30, 15, 4, 4, 3, 8'hff);
    repeat (4) @(negedge clk);
    src_xy = {16'd0, 16'd0};
    dst_xy = {16'd50, 16'd20};
    size_wh = {16'd8, 16'd8};
    rop_word = 32'h0000_0F00;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if (done) ndone++;
      @(negedge clk);
    end
    check("R8 one done for one accepted start", ndone, 1);
    check("R8 start while busy ignored", diff_count(), 0);
    check("R8 idle after done", int'(busy), 0);
  endtask

  initial begin
    fill(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_plain();
    t_overlap();
    t_rops();
    t_clamp_skip();
    t_ctrl_plane();
    t_zero_size();
    t_busy_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule